// File: doc/BRIEF.md
# Low-Power Stop Clock Gating Controller

This block controls how the chip's clocks behave while a low-power stop is in force and while the chip wakes from it. A one-cycle stop strobe puts it into stop. At that moment it samples three mode bits. The processor-only bit selects between two regimes. In the first, the whole intermodule bus clock is frozen and only a trace, a reset exception or a system-integration interrupt wakes the chip. In the second, only the processor's branch of that clock is gated off, and an interrupt from any module also wakes it.

The second bit decides what drives the system-integration clock during stop. It either stays on the VCO, or it moves to the crystal and the VCO gets a power-down request. The move uses a break-before-make switch. The third bit decides whether the external clock output keeps carrying the system-integration clock during stop or is held low.

Separately, a divider produces the external bus clock from the system clock at a rate of 1/8 or 1/16. It runs only while its pin-assignment enable is set. It returns to a known phase whenever the rate bit changes or the enable is dropped. All gating uses latch-based enables that are updated only while the gated clock is low.

Top module: `lpstop_clkctl`

## Requirements
- R1: After reset, the bus clock, the processor clock and the clock output all run at the VCO rate. The crystal-select output (`sim_src_xtal`) is 0, the power-down request is 0, and the external bus clock is low while its enable is 0.
- R2: With `cfg_cpu_only`=0 at stop entry, both `imb_clk` and `cpu_clk` are held low for the whole stop.
- R3: With `cfg_cpu_only`=0, only `wake_trace`, `wake_rst_exc` or `wake_sim_irq` ends the stop. `wake_mod_irq` alone leaves `imb_clk` and `cpu_clk` held low.
- R4: With `cfg_cpu_only`=1 at stop entry, `imb_clk` keeps running at the VCO rate and `cpu_clk` is held low.
- R5: With `cfg_cpu_only`=1, any of the four wake inputs, `wake_mod_irq` included, restarts `cpu_clk`. After wake the outputs return to the R1 state.
- R6: With `cfg_sim_on_vco`=0 at entry, during stop `sim_src_xtal`=1 and `vco_pd_req`=1, and the system-integration clock runs at the crystal rate. With `cfg_sim_on_vco`=1, both outputs stay 0.
- R7: With `cfg_ext_in_stop`=0 at entry, `clk_out` is held low during stop. With it set to 1, `clk_out` carries the system-integration clock chosen per R6.
- R8: With `eclk_pin_en`=1, `eclk` has a period of 8 VCO cycles when `cfg_ediv16`=0 and 16 when it is 1, with 50% duty.
- R9: When `eclk_pin_en` is 0, `eclk` is low from the next VCO cycle on.
- R10: A change of `cfg_ediv16` forces `eclk` low at the next VCO edge. `eclk` then stays low for exactly half of the new period before its first rise.
- R11: The VCO source and the crystal source are never enabled onto the system-integration clock at the same time. Each enable changes only after two synchronising cycles of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Synthesised system clock |
| clk_xtal | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle stop entry strobe, system-integration clock domain |
| wake_trace | input | 1 | Trace wake event, level |
| wake_rst_exc | input | 1 | Reset exception wake event, level |
| wake_sim_irq | input | 1 | System-integration interrupt, level |
| wake_mod_irq | input | 1 | Interrupt from any other module, level |
| cfg_cpu_only | input | 1 | 1: gate only the processor branch during stop |
| cfg_sim_on_vco | input | 1 | 1: keep the system-integration clock on the VCO during stop |
| cfg_ext_in_stop | input | 1 | 1: keep driving clk_out during stop |
| cfg_ediv16 | input | 1 | External bus clock divide: 0 = /8, 1 = /16 |
| eclk_pin_en | input | 1 | Pin-assignment enable for the external bus clock |
| imb_clk | output | 1 | Gated intermodule bus clock |
| cpu_clk | output | 1 | Gated processor clock |
| sim_src_xtal | output | 1 | 1 when the crystal drives the system-integration clock |
| vco_pd_req | output | 1 | VCO power-down request |
| clk_out | output | 1 | External clock output |
| eclk | output | 1 | Divided external bus clock |

## Verification
On every cycle, assertions check four things: the two clock sources are never enabled together, a power-down request appears only while the crystal is selected, a disabled or re-rated divider drops `eclk` at the next edge, and a module interrupt cannot end a full-freeze stop. Only the bench's sweep can show the frequencies. It crosses all eight mode-bit combinations with each of the four wake sources and counts clock edges over fixed windows to confirm which clock runs, at which rate, and which wake source restarts it. The duty cycle and re-phase timing of the external bus clock are measured from sampled waveforms.

// File: rtl/lpstop_pkg.sv
`timescale 1ns/1ps
package lpstop_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_STOP = 1'b1} lps_state_e;

  localparam int NWAKE     = 4;
  localparam int WK_TRACE  = 0;
  localparam int WK_RSTEXC = 1;
  localparam int WK_SIMIRQ = 2;
  localparam int WK_MODIRQ = 3;
endpackage

// File: rtl/lpstop_icg.sv
`timescale 1ns/1ps
module lpstop_icg #(
  parameter int SYNC_STAGES = 2,
  parameter bit RST_EN      = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic gclk
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   en_l;

  // shift register bringing the enable into this clock's domain
  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = en;
    end else begin : g_many
      assign sync_d = {sync_q[SYNC_STAGES-2:0], en};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{RST_EN}};
    else        sync_q <= sync_d;
  end

  // enable latch is transparent only while clk is low
  always_latch begin
    if (!clk) en_l = sync_q[SYNC_STAGES-1];
  end

  assign gclk = clk & en_l;
endmodule

// File: rtl/lpstop_clksw.sv
`timescale 1ns/1ps
module lpstop_clksw #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_vco,
  input  logic rst_vco_n,
  input  logic clk_xtal,
  input  logic rst_xtal_n,
  input  logic sel_xtal,
  output logic clk_sim,
  output logic xtal_on,
  output logic vco_on
);
  logic [SYNC_STAGES-1:0] vsync_q, vsync_d;
  logic [SYNC_STAGES-1:0] xsync_q, xsync_d;
  logic                   vco_req, xtal_req;

  // each side may turn on only after the other side reports off
  assign vco_req  = !sel_xtal && !xtal_on;
  assign xtal_req =  sel_xtal && !vco_on;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign vsync_d = vco_req;
      assign xsync_d = xtal_req;
    end else begin : g_many
      assign vsync_d = {vsync_q[SYNC_STAGES-2:0], vco_req};
      assign xsync_d = {xsync_q[SYNC_STAGES-2:0], xtal_req};
    end
  endgenerate

  always_ff @(posedge clk_vco or negedge rst_vco_n) begin
    if (!rst_vco_n) vsync_q <= '1;
    else            vsync_q <= vsync_d;
  end

  always_ff @(negedge clk_vco or negedge rst_vco_n) begin
    if (!rst_vco_n) vco_on <= 1'b1;
    else            vco_on <= vsync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_xtal or negedge rst_xtal_n) begin
    if (!rst_xtal_n) xsync_q <= '0;
    else             xsync_q <= xsync_d;
  end

  always_ff @(negedge clk_xtal or negedge rst_xtal_n) begin
    if (!rst_xtal_n) xtal_on <= 1'b0;
    else             xtal_on <= xsync_q[SYNC_STAGES-1];
  end

  assign clk_sim = (clk_vco & vco_on) | (clk_xtal & xtal_on);

  assert_src_exclusive_R11: assert property (@(posedge clk_vco) disable iff (!rst_vco_n)
    !(vco_on && xtal_on))
    else $error("both clock sources enabled");
endmodule

// File: rtl/lpstop_eclkdiv.sv
`timescale 1ns/1ps
module lpstop_eclkdiv #(
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic slow,
  output logic eclk
);
  localparam int           CW       = $clog2(DIV_SLOW / 2);
  localparam logic [CW-1:0] LIM_FAST = CW'(DIV_FAST / 2 - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(DIV_SLOW / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          eclk_q, eclk_d;
  logic          slow_q;
  logic          rephase;
  logic [CW-1:0] lim;

  assign lim     = slow ? LIM_SLOW : LIM_FAST;
  assign rephase = !en || (slow != slow_q);

  always_comb begin
    cnt_d  = cnt_q;
    eclk_d = eclk_q;
    if (rephase) begin
      cnt_d  = '0;
      eclk_d = 1'b0;
    end else if (cnt_q == lim) begin
      cnt_d  = '0;
      eclk_d = !eclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      eclk_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      eclk_q <= eclk_d;
      slow_q <= slow;
    end
  end

  assign eclk = eclk_q;

  assert_eclk_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !eclk)
    else $error("eclk running while disabled");

  assert_rephase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slow != slow_q) |=> !eclk)
    else $error("eclk not re-phased on rate change");
endmodule

// File: rtl/lpstop_seq.sv
`timescale 1ns/1ps
module lpstop_seq
  import lpstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [NWAKE-1:0] wake_in,
  input  logic             cfg_cpu_only,
  input  logic             cfg_sim_on_vco,
  input  logic             cfg_ext_in_stop,
  input  logic             xtal_active,
  output logic             imb_en,
  output logic             cpu_en,
  output logic             sel_xtal,
  output logic             clkout_en,
  output logic             vco_pd_req
);
  localparam int SW = NWAKE + 1;

  lps_state_e    state_q, state_d;
  logic          cpu_only_q, cpu_only_d;
  logic          on_vco_q, on_vco_d;
  logic          ext_q, ext_d;
  logic [SW-1:0] sync_q [SYNC_STAGES];
  logic [SW-1:0] sync_last;
  logic [NWAKE-1:0] wake_s;
  logic          xtal_s;
  logic          wake_narrow, wake_any, wake_hit;

  // wake levels and the crystal status arrive from other domains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= {xtal_active, wake_in};
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= '0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign sync_last = sync_q[SYNC_STAGES-1];
  assign wake_s    = sync_last[NWAKE-1:0];
  assign xtal_s    = sync_last[NWAKE];

  assign wake_narrow = wake_s[WK_TRACE] | wake_s[WK_RSTEXC] | wake_s[WK_SIMIRQ];
  assign wake_any    = wake_narrow | wake_s[WK_MODIRQ];
  assign wake_hit    = cpu_only_q ? wake_any : wake_narrow;

  always_comb begin
    state_d    = state_q;
    cpu_only_d = cpu_only_q;
    on_vco_d   = on_vco_q;
    ext_d      = ext_q;
    case (state_q)
      ST_RUN: begin
        if (stop_req) begin
          state_d    = ST_STOP;
          cpu_only_d = cfg_cpu_only;
          on_vco_d   = cfg_sim_on_vco;
          ext_d      = cfg_ext_in_stop;
        end
      end
      default: begin
        if (wake_hit) state_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      cpu_only_q <= 1'b0;
      on_vco_q   <= 1'b1;
      ext_q      <= 1'b1;
    end else begin
      state_q    <= state_d;
      cpu_only_q <= cpu_only_d;
      on_vco_q   <= on_vco_d;
      ext_q      <= ext_d;
    end
  end

  assign cpu_en     = (state_q == ST_RUN);
  assign imb_en     = (state_q == ST_RUN) || cpu_only_q;
  assign sel_xtal   = (state_q == ST_STOP) && !on_vco_q;
  assign clkout_en  = (state_q == ST_RUN) || ext_q;
  assign vco_pd_req = sel_xtal && xtal_s;

  assert_narrow_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !cpu_only_q && !wake_narrow) |=> (state_q == ST_STOP))
    else $error("full-freeze stop left without a narrow wake event");
endmodule

// File: rtl/lpstop_clkctl.sv
`timescale 1ns/1ps
module lpstop_clkctl
  import lpstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int DIV_FAST    = 8,
  parameter int DIV_SLOW    = 16
) (
  input  logic clk_vco,
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic stop_req,
  input  logic wake_trace,
  input  logic wake_rst_exc,
  input  logic wake_sim_irq,
  input  logic wake_mod_irq,
  input  logic cfg_cpu_only,
  input  logic cfg_sim_on_vco,
  input  logic cfg_ext_in_stop,
  input  logic cfg_ediv16,
  input  logic eclk_pin_en,
  output logic imb_clk,
  output logic cpu_clk,
  output logic sim_src_xtal,
  output logic vco_pd_req,
  output logic clk_out,
  output logic eclk
);
  localparam int NDOM  = 3;
  localparam int D_VCO = 0;
  localparam int D_XTL = 1;
  localparam int D_SIM = 2;

  logic [NDOM-1:0]  dom_clk;
  logic [NDOM-1:0]  dom_rst_n;
  logic             clk_sim;
  logic             xtal_on, vco_on;
  logic             imb_en, cpu_en, sel_xtal, clkout_en;
  logic [NWAKE-1:0] wake_vec;

  assign dom_clk[D_VCO] = clk_vco;
  assign dom_clk[D_XTL] = clk_xtal;
  assign dom_clk[D_SIM] = clk_sim;

  // reset asserts at once and is released on each domain's own clock
  generate
    for (genvar d = 0; d < NDOM; d++) begin : g_rst
      logic [RST_STAGES-1:0] rs_q;
      always_ff @(posedge dom_clk[d] or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
      end
      assign dom_rst_n[d] = rs_q[RST_STAGES-1];
    end
  endgenerate

  assign wake_vec[WK_TRACE]  = wake_trace;
  assign wake_vec[WK_RSTEXC] = wake_rst_exc;
  assign wake_vec[WK_SIMIRQ] = wake_sim_irq;
  assign wake_vec[WK_MODIRQ] = wake_mod_irq;

  lpstop_clksw #(.SYNC_STAGES(SYNC_STAGES)) u_clksw (
    .clk_vco    (clk_vco),
    .rst_vco_n  (dom_rst_n[D_VCO]),
    .clk_xtal   (clk_xtal),
    .rst_xtal_n (dom_rst_n[D_XTL]),
    .sel_xtal   (sel_xtal),
    .clk_sim    (clk_sim),
    .xtal_on    (xtal_on),
    .vco_on     (vco_on)
  );

  lpstop_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk             (clk_sim),
    .rst_n           (dom_rst_n[D_SIM]),
    .stop_req        (stop_req),
    .wake_in         (wake_vec),
    .cfg_cpu_only    (cfg_cpu_only),
    .cfg_sim_on_vco  (cfg_sim_on_vco),
    .cfg_ext_in_stop (cfg_ext_in_stop),
    .xtal_active     (xtal_on),
    .imb_en          (imb_en),
    .cpu_en          (cpu_en),
    .sel_xtal        (sel_xtal),
    .clkout_en       (clkout_en),
    .vco_pd_req      (vco_pd_req)
  );

  lpstop_icg #(.SYNC_STAGES(SYNC_STAGES), .RST_EN(1'b1)) u_gate_imb (
    .clk (clk_vco), .rst_n (dom_rst_n[D_VCO]), .en (imb_en), .gclk (imb_clk)
  );

  lpstop_icg #(.SYNC_STAGES(SYNC_STAGES), .RST_EN(1'b1)) u_gate_cpu (
    .clk (clk_vco), .rst_n (dom_rst_n[D_VCO]), .en (cpu_en), .gclk (cpu_clk)
  );

  lpstop_icg #(.SYNC_STAGES(1), .RST_EN(1'b1)) u_gate_out (
    .clk (clk_sim), .rst_n (dom_rst_n[D_SIM]), .en (clkout_en), .gclk (clk_out)
  );

  lpstop_eclkdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_ediv (
    .clk   (clk_vco),
    .rst_n (dom_rst_n[D_VCO]),
    .en    (eclk_pin_en),
    .slow  (cfg_ediv16),
    .eclk  (eclk)
  );

  assign sim_src_xtal = xtal_on;

  assert_pd_needs_xtal_R6: assert property (@(posedge clk_xtal) disable iff (!dom_rst_n[D_XTL])
    vco_pd_req |-> sim_src_xtal)
    else $error("VCO power-down requested before crystal took over");
endmodule

// File: tb/lpstop_clkctl_tb.sv
`timescale 1ns/1ps
module lpstop_clkctl_tb;
  localparam int WIN   = 60;   // counting window, VCO cycles
  localparam int XRATE = 20;   // crystal edges expected in WIN (30 ns period)

  logic clk_vco, clk_xtal, rst_n;
  logic stop_req, w_trace, w_rexc, w_sim, w_mod;
  logic c_cpu, c_vco, c_ext, c_ediv, e_en;
  logic imb_clk, cpu_clk, sim_src_xtal, vco_pd_req, clk_out, eclk;

  int n_vec = 0, n_bad = 0;
  int e_imb = 0, e_cpu = 0, e_out = 0;
  int c_imb, c_cpu_n, c_out_n;
  bit done = 0;

  lpstop_clkctl u_dut (
    .clk_vco(clk_vco), .clk_xtal(clk_xtal), .rst_n(rst_n), .stop_req(stop_req),
    .wake_trace(w_trace), .wake_rst_exc(w_rexc), .wake_sim_irq(w_sim),
    .wake_mod_irq(w_mod), .cfg_cpu_only(c_cpu), .cfg_sim_on_vco(c_vco),
    .cfg_ext_in_stop(c_ext), .cfg_ediv16(c_ediv), .eclk_pin_en(e_en),
    .imb_clk(imb_clk), .cpu_clk(cpu_clk), .sim_src_xtal(sim_src_xtal),
    .vco_pd_req(vco_pd_req), .clk_out(clk_out), .eclk(eclk)
  );

  initial begin clk_vco = 1'b0; forever #5 clk_vco = !clk_vco; end
  initial begin clk_xtal = 1'b0; #2; forever #15 clk_xtal = !clk_xtal; end

  always @(posedge imb_clk) e_imb++;
  always @(posedge cpu_clk) e_cpu++;
  always @(posedge clk_out) e_out++;

  task automatic chk(input string req, input int act, input int lo, input int hi);
    n_vec++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // edge counts of the three gated clocks over WIN VCO cycles
  task automatic window();
    int a, b, c;
    a = e_imb; b = e_cpu; c = e_out;
    repeat (WIN) @(negedge clk_vco);
    c_imb = e_imb - a; c_cpu_n = e_cpu - b; c_out_n = e_out - c;
  endtask

  function automatic int rlo(input int r); return (r == 0) ? 0 : r - 1; endfunction
  function automatic int rhi(input int r); return (r == 0) ? 0 : r + 1; endfunction

  task automatic drive_wake(input int src, input logic v);
    case (src)
      0: w_trace = v;
      1: w_rexc  = v;
      2: w_sim   = v;
      default: w_mod = v;
    endcase
  endtask

  task automatic pulse_wake(input int src);
    drive_wake(src, 1'b1);
    repeat (30) @(negedge clk_vco);
    drive_wake(src, 1'b0);
    repeat (30) @(negedge clk_vco);
  endtask

  // period and high time of eclk from negedge samples
  task automatic measure_eclk(output int per, output int hi);
    int guard;
    guard = 0;
    while (eclk !== 1'b0 && guard < 100) begin @(negedge clk_vco); guard++; end
    while (eclk !== 1'b1 && guard < 100) begin @(negedge clk_vco); guard++; end
    per = 0; hi = 0;
    do begin
      if (eclk === 1'b1) hi++;
      per++;
      @(negedge clk_vco);
    end while (!(eclk === 1'b1 && per > 1 && hi < per) && per < 100);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int per, hi, lowrun, hsum;
    rst_n = 0; stop_req = 0; w_trace = 0; w_rexc = 0; w_sim = 0; w_mod = 0;
    c_cpu = 0; c_vco = 0; c_ext = 0; c_ediv = 0; e_en = 0;
    repeat (5) @(negedge clk_vco);
    rst_n = 1;
    repeat (30) @(negedge clk_vco);

    // R1 reset state, R9 eclk disabled
    hsum = 0;
    begin
      int a, b, c;
      a = e_imb; b = e_cpu; c = e_out;
      for (int i = 0; i < WIN; i++) begin @(negedge clk_vco); hsum += int'(eclk); end
      c_imb = e_imb - a; c_cpu_n = e_cpu - b; c_out_n = e_out - c;
    end
    chk("R1 imb_clk rate", c_imb, WIN - 1, WIN + 1);
    chk("R1 cpu_clk rate", c_cpu_n, WIN - 1, WIN + 1);
    chk("R1 clk_out rate", c_out_n, WIN - 1, WIN + 1);
    chk("R1 sim_src_xtal", int'(sim_src_xtal), 0, 0);
    chk("R1 vco_pd_req", int'(vco_pd_req), 0, 0);
    chk("R9 eclk idle high samples", hsum, 0, 0);

    // sweep every mode combination against every wake source
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int src = 0; src < 4; src++) begin
        int imb_x, out_x;
        bit woke;
        c_cpu = cfg[0]; c_vco = cfg[1]; c_ext = cfg[2];
        @(negedge clk_vco); stop_req = 1;
        @(negedge clk_vco); stop_req = 0;
        c_cpu = !cfg[0]; c_vco = !cfg[1]; c_ext = !cfg[2]; // ignored once latched
        repeat (40) @(negedge clk_vco);
        window();
        imb_x = cfg[0] ? WIN : 0;
        out_x = !cfg[2] ? 0 : (cfg[1] ? WIN : XRATE);
        if (cfg[0]) begin
          chk("R4 imb_clk runs in processor-only stop", c_imb, rlo(imb_x), rhi(imb_x));
          chk("R4 cpu_clk held", c_cpu_n, 0, 0);
        end else begin
          chk("R2 imb_clk held", c_imb, 0, 0);
          chk("R2 cpu_clk held", c_cpu_n, 0, 0);
        end
        chk("R6 sim_src_xtal in stop", int'(sim_src_xtal), int'(!cfg[1]), int'(!cfg[1]));
        chk("R6 vco_pd_req in stop", int'(vco_pd_req), int'(!cfg[1]), int'(!cfg[1]));
        chk("R7 clk_out in stop", c_out_n, rlo(out_x), rhi(out_x));

        pulse_wake(src);
        woke = (src != 3) || cfg[0];
        window();
        if (!woke) begin
          chk("R3 module irq leaves cpu_clk held", c_cpu_n, 0, 0);
          chk("R3 module irq leaves imb_clk held", c_imb, 0, 0);
          pulse_wake(0);
          window();
        end
        if (cfg[0]) chk("R5 cpu_clk after wake", c_cpu_n, WIN - 1, WIN + 1);
        else        chk("R3 cpu_clk after narrow wake", c_cpu_n, WIN - 1, WIN + 1);
        chk("R5 imb_clk after wake", c_imb, WIN - 1, WIN + 1);
        chk("R5 clk_out after wake", c_out_n, WIN - 1, WIN + 1);
        chk("R5 sim_src_xtal after wake", int'(sim_src_xtal), 0, 0);
        chk("R5 vco_pd_req after wake", int'(vco_pd_req), 0, 0);
      end
    end

    // R8 divide rates, R10 re-phase on rate change
    for (int r = 0; r < 2; r++) begin
      int div;
      div = r ? 16 : 8;
      c_ediv = r[0]; e_en = 1;
      repeat (40) @(negedge clk_vco);
      measure_eclk(per, hi);
      chk("R8 eclk period", per, div, div);
      chk("R8 eclk high time", hi, div / 2, div / 2);
      // flip the rate while eclk is high
      while (eclk !== 1'b1) @(negedge clk_vco);
      c_ediv = !c_ediv;
      lowrun = 0;
      @(negedge clk_vco);
      while (eclk === 1'b0 && lowrun < 40) begin lowrun++; @(negedge clk_vco); end
      chk("R10 low run after rate change", lowrun, (div == 8 ? 16 : 8) / 2, (div == 8 ? 16 : 8) / 2);
    end

    // R9 disable forces eclk low
    while (eclk !== 1'b1) @(negedge clk_vco);
    e_en = 0;
    @(negedge clk_vco);
    hsum = 0;
    for (int i = 0; i < 40; i++) begin hsum += int'(eclk); @(negedge clk_vco); end
    chk("R9 eclk held low when disabled", hsum, 0, 0);

    done = 1;
    summary();
  end
endmodule